// File: doc/BRIEF.md
# Two-Segment Page-Table Entry Address Translator

This block serves a page-table walker that splits the virtual address space into two halves, each with its own table. The most significant virtual address bit picks the half. The lower half holds a heap-like region whose table grows upward from page zero. The upper half holds a stack-like region whose table grows downward from the highest page. Each half has two registers: a table base, which is a byte address, and a limit, which gives the number of pages the table currently covers.

For each request the block works out the page index within the selected half. For the upper half the index is counted down from the top. The block compares that index against the limit of the half. When the index is inside the limit, it returns the byte address of the table entry to read. When it is outside, it raises a limit fault that carries the faulting virtual address, so that software can extend the table and retry.

The result appears one clock after the request. Software loads the bases and limits through a small write port.

Top module: `seg_xlate_top`

## Requirements
- R1: While reset is low (synchronous), every base and limit register clears to zero and `xl_valid`, `limit_fault`, `seg_sel`, `pte_addr` and `fault_va` clear to zero. As a result, every request after reset faults until its segment has been configured.
- R2: Bit 31 of `req_va` selects the segment, with 0 meaning lower and 1 meaning upper. On the clock edge that samples a request, `seg_sel` takes that bit.
- R3: Lower segment. The page index is `req_va[30:12]`. The request passes when the index is less than the lower limit. On a pass, `pte_addr = lower_base + 4*index`.
- R4: Upper segment. The index is `(2^19 - 1) - req_va[30:12]`, so the highest page has index 0. The request passes when the index is less than the upper limit. On a pass, `pte_addr = upper_base + 4*index`.
- R5: A request that fails its check raises `limit_fault` for exactly one cycle, one clock after the request, and loads `fault_va` with the full `req_va`. `xl_valid` stays low and `pte_addr` keeps its previous value. A request that passes raises `xl_valid` for one cycle instead. The two outputs are never high together.
- R6: A write on the configuration port (`cfg_we = 1`) uses the `cfg_sel` codes 0 = lower base, 1 = lower limit, 2 = upper base, 3 = upper limit, and stores all 32 bits of `cfg_wdata`. A request sampled in the same cycle as the write sees the old value. Requests in later cycles see the new value. The registers hold their values between writes.
- R7: A cycle without `req_valid` raises neither `xl_valid` nor `limit_fault` on the next clock.
- R8: Any limit of 2^19 or greater lets every page of its segment pass. A limit of 0 faults every page.
- R9: The entry address is computed modulo 2^32, so a base near the top of the address space wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 lower base, 1 lower limit, 2 upper base, 3 upper limit |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address to translate |
| xl_valid | output | 1 | One-cycle pulse: `pte_addr` holds a valid entry address |
| pte_addr | output | 32 | Byte address of the page-table entry |
| seg_sel | output | 1 | Segment of the last request (1 = upper) |
| limit_fault | output | 1 | One-cycle pulse: the page lies beyond the segment limit |
| fault_va | output | 32 | Virtual address of the last faulting request |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4 KiB pages and 4-byte entries, which gives a 19-bit in-segment page index. With that width, the exact edges of each limit can be reached by directed vectors. On the upper side these are the top page (index 0) and the pages at index limit-1 and limit. Full-segment limits of 2^19 and above can be reached the same way. Random traffic aims half of its addresses within a few pages of the current limit in either segment. It also mixes configuration writes into request cycles, which exposes same-cycle ordering mistakes and mistakes in the direction of the comparison.

// File: rtl/seg_xlate_pkg.sv
// Package: shared encodings for the two-segment translator.
// Assumes: two segments only; the select code bit 1 picks the segment and
// bit 0 picks limit (1) versus base (0).
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        CFG_LO_BASE = 2'd0,
        CFG_LO_LIM  = 2'd1,
        CFG_HI_BASE = 2'd2,
        CFG_HI_LIM  = 2'd3
    } cfg_sel_e;

    localparam int NUM_SEG = 2;

endpackage

// File: rtl/seg_cfg_regs.sv
// Module: base and limit registers for both segments.
// Assumes: cfg_sel bit 1 is the segment, bit 0 chooses limit over base;
// all registers clear to zero on synchronous active-low reset.
module seg_cfg_regs #(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic [1:0][ADDR_W-1:0] base_q,
    output logic [1:0][ADDR_W-1:0] limit_q
);
    import seg_xlate_pkg::*;

    logic past_ok;

    // Tracks that at least one cycle has passed since reset, for assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        // Stores base or limit for segment s when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[s]  <= '0;
                limit_q[s] <= '0;
            end else if (cfg_we && (cfg_sel[1] == 1'(s))) begin
                if (cfg_sel[0]) limit_q[s] <= cfg_wdata;
                else            base_q[s]  <= cfg_wdata;
            end
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cfg_we)) |-> ($stable(base_q) && $stable(limit_q))) // R6
        else $error("config register changed without a write");

endmodule

// File: rtl/seg_unit.sv
// Module: per-segment index, limit check and entry address.
// Assumes: GROWS_DOWN=1 counts the index from the top page of the segment,
// which in SEG_VPN_W bits is the bitwise complement of the page number.
module seg_unit #(
    parameter int ADDR_W      = 32,
    parameter int SEG_VPN_W   = 19,
    parameter int ENTRY_SHIFT = 2,
    parameter bit GROWS_DOWN  = 1'b0
) (
    input  logic [SEG_VPN_W-1:0] vpn,
    input  logic [ADDR_W-1:0]    base,
    input  logic [ADDR_W-1:0]    limit,
    output logic                 in_range,
    output logic [ADDR_W-1:0]    entry_addr
);
    logic [SEG_VPN_W-1:0] idx;
    logic [ADDR_W-1:0]    idx_ext;

    if (GROWS_DOWN) begin : g_down
        // Index counts down from the highest page of the segment.
        always_comb idx = ~vpn;
    end else begin : g_up
        // Index counts up from the lowest page of the segment.
        always_comb idx = vpn;
    end

    // Compares the index with the limit and forms the entry byte address.
    always_comb begin
        idx_ext    = ADDR_W'(idx);
        in_range   = idx_ext < limit;
        entry_addr = base + (idx_ext << ENTRY_SHIFT);
    end

endmodule

// File: rtl/seg_resp.sv
// Module: registered response stage producing one-cycle result pulses.
// Assumes: pte_addr updates only on a passing request, fault_va only on a fault.
module seg_resp #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_addr,
    output logic              xl_valid,
    output logic [ADDR_W-1:0] pte_addr,
    output logic              seg_sel,
    output logic              limit_fault,
    output logic [ADDR_W-1:0] fault_va
);
    logic past_ok;

    // Tracks that at least one cycle has passed since reset, for assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Captures the outcome of a request into the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid    <= 1'b0;
            limit_fault <= 1'b0;
            seg_sel     <= 1'b0;
            pte_addr    <= '0;
            fault_va    <= '0;
        end else begin
            xl_valid    <= req_valid && hit;
            limit_fault <= req_valid && !hit;
            if (req_valid) seg_sel <= req_va[ADDR_W-1];
            if (req_valid && hit)  pte_addr <= hit_addr;
            if (req_valid && !hit) fault_va <= req_va;
        end
    end

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xl_valid, limit_fault})) // R5
        else $error("pass and fault together");

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(req_valid)) |-> (!xl_valid && !limit_fault)) // R7
        else $error("result pulse without request");

    AST_FAULT_VA: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && limit_fault) |-> (fault_va == $past(req_va))) // R5
        else $error("fault address mismatch");

    AST_SEG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (xl_valid || limit_fault)) |-> (seg_sel == $past(req_va[ADDR_W-1]))) // R2
        else $error("segment select mismatch");

endmodule

// File: rtl/seg_xlate_top.sv
// Module: two-segment limit-checked page-table entry address translator.
// Assumes: the top address bit picks the segment; the lower segment table grows
// up, the upper one grows down; one-cycle registered latency.
module seg_xlate_top #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_OFF_W  = 12,
    parameter int ENTRY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    output logic              xl_valid,
    output logic [ADDR_W-1:0] pte_addr,
    output logic              seg_sel,
    output logic              limit_fault,
    output logic [ADDR_W-1:0] fault_va
);
    import seg_xlate_pkg::*;

    localparam int SEG_VPN_W   = ADDR_W - 1 - PAGE_OFF_W;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [1:0][ADDR_W-1:0] base_q;
    logic [1:0][ADDR_W-1:0] limit_q;
    logic [NUM_SEG-1:0]     seg_hit;
    logic [ADDR_W-1:0]      seg_addr [NUM_SEG];
    logic [SEG_VPN_W-1:0]   vpn;
    logic                   sel;
    logic                   hit;
    logic [ADDR_W-1:0]      hit_addr;

    seg_cfg_regs #(.ADDR_W(ADDR_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .limit_q   (limit_q)
    );

    // Splits the address into segment bit and in-segment page number.
    always_comb begin
        sel = req_va[ADDR_W-1];
        vpn = req_va[ADDR_W-2:PAGE_OFF_W];
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_unit
        seg_unit #(
            .ADDR_W      (ADDR_W),
            .SEG_VPN_W   (SEG_VPN_W),
            .ENTRY_SHIFT (ENTRY_SHIFT),
            .GROWS_DOWN  (s == 1)
        ) unit_i (
            .vpn        (vpn),
            .base       (base_q[s]),
            .limit      (limit_q[s]),
            .in_range   (seg_hit[s]),
            .entry_addr (seg_addr[s])
        );
    end

    // Picks the result of the segment named by the top address bit.
    always_comb begin
        hit      = seg_hit[sel];
        hit_addr = seg_addr[sel];
    end

    seg_resp #(.ADDR_W(ADDR_W)) resp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_va      (req_va),
        .hit         (hit),
        .hit_addr    (hit_addr),
        .xl_valid    (xl_valid),
        .pte_addr    (pte_addr),
        .seg_sel     (seg_sel),
        .limit_fault (limit_fault),
        .fault_va    (fault_va)
    );

endmodule

// File: tb/seg_xlate_top_tb_top.sv
// Bench: directed corners plus seeded random traffic, checked against a model.
module seg_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        xl_valid, seg_sel, limit_fault;
    logic [31:0] pte_addr, fault_va;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [31:0] m_base [2];
    logic [31:0] m_lim  [2];
    logic [31:0] m_pte = '0;
    logic [31:0] m_fva = '0;
    logic        m_seg = 1'b0;

    always #4 clk = ~clk;

    seg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_va(req_va),
        .xl_valid(xl_valid), .pte_addr(pte_addr), .seg_sel(seg_sel),
        .limit_fault(limit_fault), .fault_va(fault_va)
    );

    function automatic logic [31:0] idx_of(input logic [31:0] va);
        logic [31:0] v;
        v = {13'd0, va[30:12]};
        return va[31] ? (32'h7FFFF - v) : v;
    endfunction

    function automatic logic exp_hit(input logic [31:0] va);
        return idx_of(va) < m_lim[va[31]];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One cycle: optional write and optional request, then check the outputs.
    task automatic cyc(input string req, input logic we, input logic [1:0] sel,
                       input logic [31:0] wd, input logic rv, input logic [31:0] va);
        logic h;
        h = exp_hit(va);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; req_valid = rv; req_va = va;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        if (rv) begin
            m_seg = va[31];
            if (h) m_pte = m_base[va[31]] + (idx_of(va) << 2);
            else   m_fva = va;
        end
        if (we) begin
            if (sel[0]) m_lim[sel[1]] = wd;
            else        m_base[sel[1]] = wd;
        end
        chk({req, " xl_valid"}, {31'd0, xl_valid}, {31'd0, rv && h});
        chk({req, " limit_fault"}, {31'd0, limit_fault}, {31'd0, rv && !h});
        chk({req, " seg_sel"}, {31'd0, seg_sel}, {31'd0, m_seg});
        chk({req, " pte_addr"}, pte_addr, m_pte);
        chk({req, " fault_va"}, fault_va, m_fva);
    endtask

    task automatic wr(input string req, input logic [1:0] sel, input logic [31:0] wd);
        cyc(req, 1'b1, sel, wd, 1'b0, 32'd0);
    endtask

    function automatic logic [31:0] va_lo(input logic [31:0] p);
        return {1'b0, p[18:0], 12'h5A4};
    endfunction

    function automatic logic [31:0] va_hi_idx(input logic [31:0] i);
        logic [31:0] p;
        p = 32'h7FFFF - i;
        return {1'b1, p[18:0], 12'h010};
    endfunction

    initial begin
        #20_000_000;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] a, w;
        m_base[0] = '0; m_base[1] = '0; m_lim[0] = '0; m_lim[1] = '0;
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and faulting accesses before configuration
        chk("R1 xl_valid", {31'd0, xl_valid}, 32'd0);
        chk("R1 limit_fault", {31'd0, limit_fault}, 32'd0);
        chk("R1 pte_addr", pte_addr, 32'd0);
        chk("R1 fault_va", fault_va, 32'd0);
        cyc("R1 lo unconfigured", 1'b0, 2'd0, 0, 1'b1, va_lo(0));
        cyc("R1 hi unconfigured", 1'b0, 2'd0, 0, 1'b1, va_hi_idx(0));
        // R6 encodings, R3 lower segment edges
        wr("R6 lo base", 2'd0, 32'h0010_0000);
        wr("R6 lo lim", 2'd1, 32'd16);
        cyc("R3 lo idx0", 1'b0, 2'd0, 0, 1'b1, va_lo(0));
        cyc("R3 lo idx15", 1'b0, 2'd0, 0, 1'b1, va_lo(15));
        cyc("R3 lo idx16", 1'b0, 2'd0, 0, 1'b1, va_lo(16));
        cyc("R2 hi still zero", 1'b0, 2'd0, 0, 1'b1, va_hi_idx(3));
        // R4 upper segment edges
        wr("R6 hi base", 2'd2, 32'h0020_0000);
        wr("R6 hi lim", 2'd3, 32'd8);
        cyc("R4 hi top page", 1'b0, 2'd0, 0, 1'b1, va_hi_idx(0));
        cyc("R4 hi idx7", 1'b0, 2'd0, 0, 1'b1, va_hi_idx(7));
        cyc("R4 hi idx8", 1'b0, 2'd0, 0, 1'b1, va_hi_idx(8));
        cyc("R2 hi lowest page", 1'b0, 2'd0, 0, 1'b1, {1'b1, 31'd0});
        // R7 idle cycles
        cyc("R7 idle", 1'b0, 2'd0, 0, 1'b0, va_lo(1));
        cyc("R7 idle with write", 1'b1, 2'd0, 32'h0010_0000, 1'b0, va_hi_idx(1));
        // R6 same-cycle write sees old value
        cyc("R6 same cycle lim", 1'b1, 2'd1, 32'd17, 1'b1, va_lo(16));
        cyc("R6 after write", 1'b0, 2'd0, 0, 1'b1, va_lo(16));
        cyc("R6 same cycle base", 1'b1, 2'd2, 32'h0300_0000, 1'b1, va_hi_idx(2));
        cyc("R6 base applied", 1'b0, 2'd0, 0, 1'b1, va_hi_idx(2));
        // R8 full and oversized limits, zero limit
        wr("R8 lo full", 2'd1, 32'h0008_0000);
        cyc("R8 lo last page", 1'b0, 2'd0, 0, 1'b1, va_lo(32'h7FFFF));
        wr("R8 hi huge", 2'd3, 32'hFFFF_FFFF);
        cyc("R8 hi lowest page", 1'b0, 2'd0, 0, 1'b1, {1'b1, 31'h0000_0FFF});
        wr("R8 lo zero", 2'd1, 32'd0);
        cyc("R8 lo zero idx0", 1'b0, 2'd0, 0, 1'b1, va_lo(0));
        // R9 wrap
        wr("R9 lo base", 2'd0, 32'hFFFF_FFF8);
        wr("R9 lo lim", 2'd1, 32'd100);
        cyc("R9 wrap", 1'b0, 2'd0, 0, 1'b1, va_lo(5));
        // Random traffic aimed near the limits
        for (int i = 0; i < 400; i++) begin
            w = $urandom;
            if ($urandom_range(0, 3) == 0) w = $urandom_range(0, 40);
            if ($urandom_range(0, 1) == 1) begin
                a = $urandom;
            end else if ($urandom_range(0, 1) == 1) begin
                a = va_lo(m_lim[0] + 32'($urandom_range(0, 6)) - 32'd3);
            end else begin
                a = va_hi_idx(m_lim[1] + 32'($urandom_range(0, 6)) - 32'd3);
            end
            cyc("R3 R4 R5 R6 random", ($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)),
                w, ($urandom_range(0, 5) != 0), a);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule